// File: doc/BRIEF.md
# Chainable FIFO Slice with Token Hand-off

A synchronous first-in/first-out buffer slice. Several identical slices sit in a ring to form one deeper buffer. Every slice in the ring sees the same write strobe, read strobe and write data, and the ring's read data is the OR of the slices' `dout` buses. Only one slice may accept writes at a time, and only one may answer reads: each holds a write token and a read token. The write token moves on when its holder stores into its highest address. The read token moves on when its holder delivers its highest address. The hand-off is a one-clock active-low pulse on a dedicated output, wired to the matching input of the next slice in the ring.

Write and read ownership travel on two separate pulse lines, `xo_wr_n` and `xo_rd_n`. Because of this, a write wrap and a read wrap in the same clock never collide. Each slice reports its own active-low empty and full flags. Logic outside the slices forms the composite flags:
- The buffer is empty only when every slice is empty.
- The buffer is full only when every slice is full.

A slice whose two expansion inputs are tied low re-grants itself both tokens every cycle. It then works as a standalone FIFO of `DEPTH` words.

Top module: `chain_fifo_slice`

## Requirements
- R1: Reset (rst_n low, synchronous) clears both pointers to address 0, sets empty_n=0 and full_n=1, and holds xo_wr_n=1 and xo_rd_n=1. The slice whose first_load_n is 0 starts with both tokens. A slice whose first_load_n is 1 starts with neither token.
- R2: A write is accepted when wr_en=1, the slice holds the write token and full_n=1. The slice then stores din at its write pointer. A write strobe on a slice without the write token changes nothing in that slice.
- R3: xo_wr_n is 0 for exactly the cycle in which an accepted write targets address DEPTH-1. In that cycle the slice gives up the write token, and its write pointer returns to 0.
- R4: xo_rd_n is 0 for exactly the cycle in which an accepted read delivers address DEPTH-1. In that cycle the slice gives up the read token, and its read pointer returns to 0.
- R5: xi_wr_n=0 (or xi_rd_n=0) at a clock edge grants the write (or read) token from that edge on. This happens even if the same edge hands the token away. The slice's next write (or read) then uses address 0.
- R6: dout_oe=1 and dout carries the word at the read pointer, combinationally, when rd_en=1, the slice holds the read token and empty_n=1. Otherwise dout_oe=0 and dout is all zeros.
- R7: full_n=0 exactly when the slice holds DEPTH words. While full_n=0, write strobes are ignored.
- R8: empty_n=0 exactly when the slice holds no words. While empty_n=0, read strobes are ignored and dout_oe stays 0.
- R9: In a ring of slices the words come out in the order they went in. The composite empty (every empty_n=0) asserts exactly when the total stored is 0. The composite full (every full_n=0) asserts exactly when the total stored is DEPTH times the number of slices.
- R10: With xi_wr_n and xi_rd_n tied to 0 and first_load_n=0, a lone slice behaves as a DEPTH-word FIFO whose pointers wrap past address DEPTH-1.
- R11: An accepted write and an accepted read in the same cycle leave the word count, empty_n and full_n unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| first_load_n | input | 1 | 0 marks the slice owning both tokens after reset |
| wr_en | input | 1 | Shared write strobe, active high |
| rd_en | input | 1 | Shared read strobe, active high |
| din | input | WIDTH | Shared write data |
| xi_wr_n | input | 1 | Write-token grant pulse from the previous slice |
| xi_rd_n | input | 1 | Read-token grant pulse from the previous slice |
| dout | output | WIDTH | Read data, zero when not driving |
| dout_oe | output | 1 | High while this slice drives the read bus |
| empty_n | output | 1 | Low when the slice is empty |
| full_n | output | 1 | Low when the slice is full |
| xo_wr_n | output | 1 | Write-token hand-off pulse to the next slice |
| xo_rd_n | output | 1 | Read-token hand-off pulse to the next slice |

## Verification
The bench builds a ring of three 8-word slices and streams words across several full laps of both tokens. The laps cover a full buffer with extra writes and an empty buffer with extra reads. It also covers simultaneous writes and reads while the tokens sit in different slices.

Several faults are caught by tracking which slice raises `dout_oe` and when `xo_wr_n` and `xo_rd_n` pulse:
- A hand-off one cycle late would drop or duplicate a word at a slice boundary.
- A slice that obeyed strobes without the token would put two drivers on the bus.

A standalone slice with its expansion inputs tied low is used for three further cases:
- Pointer wrap-around inside one slice.
- The ignored ninth write.
- A same-cycle write and read, where a faulty counter would flip empty or full.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    typedef enum logic {
        SIDE_WR = 1'b0,
        SIDE_RD = 1'b1
    } side_e;

    localparam int unsigned MIN_DEPTH = 2;

endpackage

// File: rtl/cfs_token_ptr.sv
module cfs_token_ptr
    import cfs_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter side_e       SIDE  = SIDE_WR,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_own,
    input  logic          req,
    input  logic          allow,
    input  logic          take_n,
    output logic          fire,
    output logic [AW-1:0] ptr,
    output logic          pass_n
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic          own;
        logic [AW-1:0] ptr;
    } tok_t;

    tok_t st_d, st_q;
    logic at_last;

    always_comb begin
        st_d    = st_q;
        at_last = (st_q.ptr == LAST);
        fire    = req && st_q.own && allow;
        pass_n  = !(fire && at_last);
        if (fire) begin
            st_d.ptr = at_last ? '0 : st_q.ptr + AW'(1);
            if (at_last) st_d.own = 1'b0;
        end
        if (!take_n) st_d.own = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{own: start_own, ptr: '0};
        else        st_q <= st_d;
    end

    assign ptr = st_q.ptr;

    // R3 (write side), R4 (read side)
    pass_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_n |=> (st_q.ptr == '0))
        else $error("pointer on side %0d did not return to 0", SIDE);

    // R3, R4
    pass_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_n && take_n) |=> !st_q.own);

    // R3, R4
    pass_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_n |=> pass_n);

    // R5
    take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_n |=> st_q.own);

endmodule

// File: rtl/cfs_store.sv
module cfs_store #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned WIDTH = 9,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/cfs_occupancy.sv
module cfs_occupancy #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic empty_n,
    output logic full_n
);
    logic [CW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        case ({inc, dec})
            2'b10:   count_d = count_q + CW'(1);
            2'b01:   count_d = count_q - CW'(1);
            default: count_d = count_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign empty_n = (count_q != '0);
    assign full_n  = (count_q != CW'(DEPTH));

    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !dec) |=> !full_n);

    // R8
    empty_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty_n) |-> $past(inc));

    // R11
    both_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> ($stable(empty_n) && $stable(full_n)));

endmodule

// File: rtl/chain_fifo_slice.sv
module chain_fifo_slice
    import cfs_pkg::*;
#(
    parameter int unsigned WIDTH = 9,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first_load_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [WIDTH-1:0] din,
    input  logic             xi_wr_n,
    input  logic             xi_rd_n,
    output logic [WIDTH-1:0] dout,
    output logic             dout_oe,
    output logic             empty_n,
    output logic             full_n,
    output logic             xo_wr_n,
    output logic             xo_rd_n
);
    localparam int unsigned AW = $clog2(DEPTH);

    logic [1:0]    req_v, allow_v, take_n_v, fire_v, pass_n_v;
    logic [AW-1:0] ptr_v [2];
    logic [WIDTH-1:0] rdata;

    assign req_v    = {rd_en, wr_en};
    assign allow_v  = {empty_n, full_n};
    assign take_n_v = {xi_rd_n, xi_wr_n};

    for (genvar s = 0; s < 2; s++) begin : g_side
        cfs_token_ptr #(
            .DEPTH (DEPTH),
            .SIDE  (side_e'(s))
        ) u_tok (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_own (!first_load_n),
            .req       (req_v[s]),
            .allow     (allow_v[s]),
            .take_n    (take_n_v[s]),
            .fire      (fire_v[s]),
            .ptr       (ptr_v[s]),
            .pass_n    (pass_n_v[s])
        );
    end

    cfs_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (fire_v[SIDE_WR]),
        .dec     (fire_v[SIDE_RD]),
        .empty_n (empty_n),
        .full_n  (full_n)
    );

    cfs_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
        .clk   (clk),
        .we    (fire_v[SIDE_WR]),
        .waddr (ptr_v[SIDE_WR]),
        .wdata (din),
        .raddr (ptr_v[SIDE_RD]),
        .rdata (rdata)
    );

    assign dout_oe = fire_v[SIDE_RD];
    assign dout    = dout_oe ? rdata : '0;
    assign xo_wr_n = pass_n_v[SIDE_WR];
    assign xo_rd_n = pass_n_v[SIDE_RD];

    initial begin : depth_param_chk
        assert (DEPTH >= MIN_DEPTH) else $error("DEPTH below minimum");
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!empty_n && full_n && xo_wr_n && xo_rd_n));

    // R6
    oe_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (empty_n && rd_en));

    // R6
    bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (dout == '0));

endmodule

// File: tb/chain_fifo_slice_test.sv
`timescale 1ns/1ps
module chain_fifo_slice_test;
    localparam int W = 9;
    localparam int D = 8;
    localparam int N = 3;
    localparam int TOTAL = D * N;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [7:0] n;
    } phase_t;

    localparam int PH_N = 9;
    localparam phase_t PH [PH_N] = '{
        '{wr:1'b1, rd:1'b0, n:8'd5},
        '{wr:1'b1, rd:1'b1, n:8'd6},
        '{wr:1'b1, rd:1'b0, n:8'd22},
        '{wr:1'b0, rd:1'b1, n:8'd9},
        '{wr:1'b1, rd:1'b1, n:8'd10},
        '{wr:1'b0, rd:1'b1, n:8'd20},
        '{wr:1'b1, rd:1'b1, n:8'd3},
        '{wr:1'b1, rd:1'b0, n:8'd30},
        '{wr:1'b0, rd:1'b1, n:8'd30}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr = 1'b0, rd = 1'b0;
    logic [W-1:0] din = '0;
    logic s_wr = 1'b0, s_rd = 1'b0;
    logic [W-1:0] s_din = '0;

    logic [W-1:0] dq [N];
    logic [N-1:0] oe, en, fn, xw, xr;
    logic [W-1:0] s_dout;
    logic s_oe, s_en, s_fn, s_xw, s_xr;

    always #2.5 clk = ~clk;

    chain_fifo_slice #(.WIDTH(W), .DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .first_load_n(1'b0),
        .wr_en(wr), .rd_en(rd), .din(din),
        .xi_wr_n(xw[2]), .xi_rd_n(xr[2]),
        .dout(dq[0]), .dout_oe(oe[0]), .empty_n(en[0]), .full_n(fn[0]),
        .xo_wr_n(xw[0]), .xo_rd_n(xr[0]));

    chain_fifo_slice #(.WIDTH(W), .DEPTH(D)) u1 (
        .clk(clk), .rst_n(rst_n), .first_load_n(1'b1),
        .wr_en(wr), .rd_en(rd), .din(din),
        .xi_wr_n(xw[0]), .xi_rd_n(xr[0]),
        .dout(dq[1]), .dout_oe(oe[1]), .empty_n(en[1]), .full_n(fn[1]),
        .xo_wr_n(xw[1]), .xo_rd_n(xr[1]));

    chain_fifo_slice #(.WIDTH(W), .DEPTH(D)) u2 (
        .clk(clk), .rst_n(rst_n), .first_load_n(1'b1),
        .wr_en(wr), .rd_en(rd), .din(din),
        .xi_wr_n(xw[1]), .xi_rd_n(xr[1]),
        .dout(dq[2]), .dout_oe(oe[2]), .empty_n(en[2]), .full_n(fn[2]),
        .xo_wr_n(xw[2]), .xo_rd_n(xr[2]));

    chain_fifo_slice #(.WIDTH(W), .DEPTH(D)) u_solo (
        .clk(clk), .rst_n(rst_n), .first_load_n(1'b0),
        .wr_en(s_wr), .rd_en(s_rd), .din(s_din),
        .xi_wr_n(1'b0), .xi_rd_n(1'b0),
        .dout(s_dout), .dout_oe(s_oe), .empty_n(s_en), .full_n(s_fn),
        .xo_wr_n(s_xw), .xo_rd_n(s_xr));

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic solo(input logic w, input logic r, input logic [W-1:0] d,
                        output logic o, output logic [W-1:0] q);
        @(negedge clk);
        s_wr = w; s_rd = r; s_din = d;
        #1;
        o = s_oe; q = s_dout;
        @(posedge clk);
        #1;
        s_wr = 1'b0; s_rd = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] q [$];
        logic [W-1:0] dseq;
        logic [W-1:0] bus;
        logic o;
        logic [W-1:0] sq;
        int wr_idx, rd_idx;
        bit wok, rok;
        dseq = 9'd1;
        wr_idx = 0;
        rd_idx = 0;

        repeat (3) @(posedge clk);
        #1;
        // R1: state during and right after reset
        chk("R1 empty_n all", {29'd0, en}, 32'd0);
        chk("R1 full_n all", {29'd0, fn}, 32'h7);
        chk("R1 xo lines idle", {26'd0, xw, xr}, 32'h3f);
        chk("R1 solo empty_n", {31'd0, s_en}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Ring of three slices: R2 R3 R4 R5 R6 R7 R8 R9 R11
        for (int p = 0; p < PH_N; p++) begin
            for (int k = 0; k < int'(PH[p].n); k++) begin
                @(negedge clk);
                wr = PH[p].wr; rd = PH[p].rd; din = dseq;
                dseq = dseq + 9'd1;
                #1;
                rok = rd && (q.size() > 0);
                wok = wr && (q.size() < TOTAL);
                bus = dq[0] | dq[1] | dq[2];
                chk("R6 driving slice", {29'd0, oe},
                    rok ? (32'd1 << ((rd_idx / D) % N)) : 32'd0);
                if (rok) chk("R9 data order", {23'd0, bus}, {23'd0, q[0]});
                chk("R3 write hand-off pulse", {31'd0, xw[0]},
                    {31'd0, !(wok && (wr_idx % TOTAL == D - 1))});
                chk("R4 read hand-off pulse", {31'd0, xr[0]},
                    {31'd0, !(rok && (rd_idx % TOTAL == D - 1))});
                if (rok) begin void'(q.pop_front()); rd_idx++; end
                if (wok) begin q.push_back(din); wr_idx++; end
                @(posedge clk);
                #1;
                chk("R9 composite empty", {31'd0, (en == '0)}, {31'd0, q.size() == 0});
                chk("R9 composite full", {31'd0, (fn == '0)}, {31'd0, q.size() == TOTAL});
            end
        end
        wr = 1'b0; rd = 1'b0;

        // R10: standalone slice, fill past depth
        for (int i = 0; i < 10; i++) solo(1'b1, 1'b0, W'(100 + i), o, sq);
        chk("R7 solo full", {31'd0, s_fn}, 32'd0);
        for (int i = 0; i < 3; i++) begin
            solo(1'b0, 1'b1, '0, o, sq);
            chk("R10 solo read", {23'd0, sq}, 32'(100 + i));
        end
        chk("R7 solo not full after reads", {31'd0, s_fn}, 32'd1);
        for (int i = 0; i < 3; i++) solo(1'b1, 1'b0, W'(200 + i), o, sq);
        for (int i = 0; i < 8; i++) begin
            solo(1'b0, 1'b1, '0, o, sq);
            chk("R10 wrapped order", {23'd0, sq}, (i < 5) ? 32'(103 + i) : 32'(195 + i));
        end
        chk("R8 solo empty", {31'd0, s_en}, 32'd0);
        solo(1'b0, 1'b1, '0, o, sq);
        chk("R8 read on empty ignored", {31'd0, o}, 32'd0);
        chk("R8 bus zero on empty", {23'd0, sq}, 32'd0);

        // R11: simultaneous write and read
        solo(1'b1, 1'b0, W'(300), o, sq);
        solo(1'b1, 1'b0, W'(301), o, sq);
        solo(1'b1, 1'b1, W'(302), o, sq);
        chk("R11 concurrent read data", {23'd0, sq}, 32'd300);
        chk("R11 empty_n steady", {31'd0, s_en}, 32'd1);
        chk("R11 full_n steady", {31'd0, s_fn}, 32'd1);
        solo(1'b0, 1'b1, '0, o, sq);
        chk("R11 next word", {23'd0, sq}, 32'd301);
        solo(1'b0, 1'b1, '0, o, sq);
        chk("R11 last word", {23'd0, sq}, 32'd302);
        chk("R8 drained", {31'd0, s_en}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule